// File: doc/BRIEF.md
# Staged Panel Power Sequencer

The sequencer powers up a flat panel by walking through a fixed list of stages. Each stage raises one control line, in this order: panel supply, LVDS enable, backlight supply, backlight PWM enable and backlight enable. Four programmable waits separate the middle stages. Each wait is given in milliseconds and is counted in microsecond ticks from a free-running counter. The deadline check uses a signed difference, so it stays correct when that counter wraps.

Software or a boot controller arms the sequence with a start pulse. The block then runs in one of two ways. With `run_mode` high it works through every stage by itself, advancing as soon as each wait has elapsed. With `run_mode` low it advances only on a cycle where `poll` is high and the pending wait has already run out, and otherwise holds. A per-line presence flag suppresses a line that the board does not have, but that stage and its wait still take place. Once the final stage is reached the block stays there until reset.

Top module: `panel_power_sequencer`

## Requirements
- R1: The `stage` port encodes start=0, panel supply=1, LVDS=2, backlight supply=3, PWM=4, backlight enable=5 and done=6. It only ever moves up by exactly one. `done` is high exactly when `stage` is 6.
- R2: Output line i (bit order 0=`panel_vdd`, 1=`lvds_en`, 2=`bl_vdd`, 3=`pwm_en`, 4=`bl_en`) goes high on the advance out of stage i+1. It therefore first reads high in the same cycle that `stage` first reads i+2. Once high, it stays high.
- R3: Wait k occupies `delay_ms[8k+7:8k]` (default 8-bit fields) and is armed by the advance out of stage k+1. The next advance waits until value×1000 ticks have been counted. With a tick on every cycle, the advances are exactly value×1000 cycles apart.
- R4: The first advance (0 to 1) happens on the clock edge after the edge that samples `start`. An advance out of a stage that arms no wait (the start stage), or a stage that arms a wait of value 0, is followed by the next advance one edge later.
- R5: When `present[i]` is 0, output line i stays low. The stage still advances and its wait is still applied with unchanged length.
- R6: With `run_mode`=1, the block advances from start to done without any `poll` pulses.
- R7: With `run_mode`=0, `stage` changes only on an edge where `poll` is 1. A poll that arrives before the wait has elapsed leaves `stage` unchanged, and a due wait without a poll also leaves it unchanged.
- R8: The microsecond counter is `TIME_W` bits wide and wraps. A wait below 2^(TIME_W-1) ticks keeps its exact length when the counter wraps during the wait.
- R9: Once `stage` is 6, further `start` or `poll` pulses change neither `stage` nor any output line until reset.
- R10: After synchronous reset, all lines are low, `stage` is 0 and `done` is 0. Until `start` is seen, no `poll` or `run_mode` activity moves `stage`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms the sequence |
| run_mode | input | 1 | 1: run to completion, 0: advance only on poll |
| poll | input | 1 | Advance request in polled mode |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| delay_ms | input | 4×MS_W | Four waits in ms, field k at bits [k*MS_W +: MS_W] |
| present | input | 5 | Per-line presence flags, bit order as R2 |
| panel_vdd | output | 1 | Panel supply enable |
| lvds_en | output | 1 | LVDS data enable |
| bl_vdd | output | 1 | Backlight supply enable |
| pwm_en | output | 1 | Backlight PWM enable |
| bl_en | output | 1 | Backlight enable |
| stage | output | 3 | Current stage, encoding as R1 |
| done | output | 1 | Sequence complete |

## Verification
Every advance is one registered step. `stage` and the line it raises both change on the edge that samples the qualifying condition, so the bench records the cycle count at which each stage value first appears. It compares the gaps against the expected values: one cycle after the start edge, one cycle for undelayed or zero waits, and value×1000 cycles for each armed wait with a tick on every cycle. In polled mode, poll pulses are placed on exact edges counted from the arming advance. This places them one edge before and exactly at the deadline, so the hold and the advance are each checked in the cycle they are due. All samples are taken at the falling edge after the deciding rising edge.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int NUM_LINES = 5;
    localparam int NUM_WAITS = 4;

    typedef enum logic [2:0] {
        ST_START  = 3'd0,
        ST_PANEL  = 3'd1,
        ST_LVDS   = 3'd2,
        ST_BLVDD  = 3'd3,
        ST_PWM    = 3'd4,
        ST_BLEN   = 3'd5,
        ST_DONE   = 3'd6
    } psq_stage_e;

    typedef struct packed {
        logic       fire;
        psq_stage_e stage;
    } psq_step_t;

    function automatic psq_stage_e stage_next(psq_stage_e s);
        return psq_stage_e'(3'(s) + 3'd1);
    endfunction

    // stages 1..4 arm a wait when left; the others arm none
    function automatic logic stage_arms_wait(psq_stage_e s);
        return (s >= ST_PANEL) && (s <= ST_PWM);
    endfunction

    function automatic logic [1:0] wait_slot(psq_stage_e s);
        return 2'(3'(s) - 3'd1);
    endfunction

endpackage

// File: rtl/psq_timebase.sv
module psq_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_us,
    output logic [TIME_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (tick_us) begin
            now <= now + 1'b1;
        end
    end

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        !tick_us |=> $stable(now)); // R8

endmodule

// File: rtl/psq_deadline.sv
module psq_deadline
    import psq_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int MS_W      = 8,
    parameter int US_PER_MS = 1000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [TIME_W-1:0]           now,
    input  psq_step_t                   step,
    input  logic [NUM_WAITS*MS_W-1:0]   delay_ms,
    output logic                        due
);

    localparam logic [TIME_W-1:0] US_SCALE = TIME_W'(US_PER_MS);

    logic [MS_W-1:0]   sel_ms;
    logic [TIME_W-1:0] span;
    logic [TIME_W-1:0] deadline_q;
    logic [TIME_W-1:0] gap;

    always_comb begin
        sel_ms = delay_ms[int'(wait_slot(step.stage))*MS_W +: MS_W];
        span   = stage_arms_wait(step.stage) ? (TIME_W'(sel_ms) * US_SCALE) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            deadline_q <= '0;
        end else if (step.fire) begin
            deadline_q <= now + span;
        end
    end

    // signed distance past the deadline survives counter wrap
    assign gap = now - deadline_q;
    assign due = ~gap[TIME_W-1];

    AST_UNARMED_DUE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (step.fire && !stage_arms_wait(step.stage)) |=> due); // R4

endmodule

// File: rtl/psq_stage_ctrl.sv
module psq_stage_ctrl
    import psq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      run_mode,
    input  logic      poll,
    input  logic      due,
    output psq_step_t step
);

    psq_stage_e stage_q;
    logic       armed_q;
    logic       want;
    logic       fire;

    always_comb begin
        want = run_mode | poll;
        fire = armed_q && (stage_q != ST_DONE) && want &&
               ((stage_q == ST_START) || due);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_START;
            armed_q <= 1'b0;
        end else begin
            if (start) begin
                armed_q <= 1'b1;
            end
            if (fire) begin
                stage_q <= stage_next(stage_q);
            end
        end
    end

    assign step.fire  = fire;
    assign step.stage = stage_q;

    AST_STAGE_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (stage_q != $past(stage_q)) |-> (stage_q == stage_next($past(stage_q)))); // R1
    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (rst)
        stage_q <= ST_DONE); // R1
    AST_POLL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_mode && !poll) |=> $stable(stage_q)); // R7
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((stage_q != ST_START) && !due) |=> $stable(stage_q)); // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_DONE) |=> (stage_q == ST_DONE)); // R9

endmodule

// File: rtl/psq_lines.sv
module psq_lines
    import psq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  psq_step_t            step,
    input  logic [NUM_LINES-1:0] present,
    output logic [NUM_LINES-1:0] lines
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines[i] <= 1'b0;
            end else if (step.fire && (3'(step.stage) == 3'(i + 1)) && present[i]) begin
                lines[i] <= 1'b1;
            end
        end

        AST_ABSENT_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
            $rose(lines[i]) |-> $past(present[i])); // R5
        AST_LINE_HELD: assert property (@(posedge clk) disable iff (rst)
            lines[i] |=> lines[i]); // R2
    end

endmodule

// File: rtl/panel_power_sequencer.sv
module panel_power_sequencer
    import psq_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int MS_W      = 8,
    parameter int US_PER_MS = 1000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      run_mode,
    input  logic                      poll,
    input  logic                      tick_us,
    input  logic [NUM_WAITS*MS_W-1:0] delay_ms,
    input  logic [NUM_LINES-1:0]      present,
    output logic                      panel_vdd,
    output logic                      lvds_en,
    output logic                      bl_vdd,
    output logic                      pwm_en,
    output logic                      bl_en,
    output logic [2:0]                stage,
    output logic                      done
);

    logic [TIME_W-1:0]    now;
    logic                 due;
    psq_step_t            step;
    logic [NUM_LINES-1:0] lines;

    psq_timebase #(.TIME_W(TIME_W)) i_timebase (
        .clk     (clk),
        .rst     (rst),
        .tick_us (tick_us),
        .now     (now)
    );

    psq_deadline #(
        .TIME_W    (TIME_W),
        .MS_W      (MS_W),
        .US_PER_MS (US_PER_MS)
    ) i_deadline (
        .clk      (clk),
        .rst      (rst),
        .now      (now),
        .step     (step),
        .delay_ms (delay_ms),
        .due      (due)
    );

    psq_stage_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run_mode (run_mode),
        .poll     (poll),
        .due      (due),
        .step     (step)
    );

    psq_lines i_lines (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .present (present),
        .lines   (lines)
    );

    assign panel_vdd = lines[0];
    assign lvds_en   = lines[1];
    assign bl_vdd    = lines[2];
    assign pwm_en    = lines[3];
    assign bl_en     = lines[4];
    assign stage     = step.stage;
    assign done      = (step.stage == ST_DONE);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        AST_RISE_WITH_STAGE: assert property (@(posedge clk) disable iff (rst)
            $rose(lines[i]) |-> (stage == 3'(i + 2))); // R2
    end

    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> ($stable(lines) && done)); // R9
    AST_NO_START_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        ((stage == 3'd0) && !start) |=> (stage <= 3'd1)); // R10

endmodule

// File: tb/test_panel_power_sequencer.sv
module test_panel_power_sequencer;

    localparam int TIME_W = 14;
    localparam int MS_W   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        run_mode = 1'b0;
    logic        poll = 1'b0;
    logic        tick_us = 1'b1;
    logic [31:0] delay_ms = '0;
    logic [4:0]  present = 5'h1F;
    logic        panel_vdd, lvds_en, bl_vdd, pwm_en, bl_en, done;
    logic [2:0]  stage;
    logic [4:0]  outs;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ts = 0;
    int step_err = 0;
    int t_stage [0:7];
    int t_out [0:4];
    logic [2:0] prev_stage;
    logic [4:0] prev_outs;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    panel_power_sequencer #(.TIME_W(TIME_W), .MS_W(MS_W), .US_PER_MS(1000)) i_panel_power_sequencer (
        .clk(clk), .rst(rst), .start(start), .run_mode(run_mode), .poll(poll),
        .tick_us(tick_us), .delay_ms(delay_ms), .present(present),
        .panel_vdd(panel_vdd), .lvds_en(lvds_en), .bl_vdd(bl_vdd), .pwm_en(pwm_en),
        .bl_en(bl_en), .stage(stage), .done(done)
    );

    assign outs = {bl_en, pwm_en, bl_vdd, lvds_en, panel_vdd};

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            prev_stage <= 3'd0;
            prev_outs  <= 5'd0;
        end else begin
            if (stage != prev_stage) begin
                if (stage != prev_stage + 3'd1) step_err <= step_err + 1;
                t_stage[stage] <= cyc;
                prev_stage <= stage;
            end
            for (int i = 0; i < 5; i++) begin
                if (outs[i] && !prev_outs[i]) t_out[i] <= cyc;
            end
            prev_outs <= outs;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; poll = 1'b0; run_mode = 1'b0;
        for (int i = 0; i < 8; i++) t_stage[i] = -1;
        for (int i = 0; i < 5; i++) t_out[i] = -1;
        step_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ts = cyc;
    endtask

    // poll sampled k edges after the previous sampling edge
    task automatic poll_at(input int k);
        repeat (k - 1) @(negedge clk);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        #1;
        check(done == 1'b1, "R6 reaches done", int'(done), 1);
    endtask

    task automatic check_gaps(input int d0, input int d1, input int d2, input int d3, input string req);
        int g [4];
        g[0] = (d0 == 0) ? 1 : d0 * 1000;
        g[1] = (d1 == 0) ? 1 : d1 * 1000;
        g[2] = (d2 == 0) ? 1 : d2 * 1000;
        g[3] = (d3 == 0) ? 1 : d3 * 1000;
        check(t_stage[1] - ts == 1, {req, " R4 start to stage1"}, t_stage[1] - ts, 1);
        check(t_stage[2] - t_stage[1] == 1, {req, " R4 stage1 to stage2"}, t_stage[2] - t_stage[1], 1);
        for (int k = 0; k < 4; k++) begin
            check(t_stage[k + 3] - t_stage[k + 2] == g[k], {req, " R3 wait gap"},
                  t_stage[k + 3] - t_stage[k + 2], g[k]);
        end
        check(step_err == 0, {req, " R1 single steps"}, step_err, 0);
    endtask

    task automatic test_reset();
        do_reset();
        @(negedge clk);
        check(stage == 3'd0, "R10 reset stage", int'(stage), 0);
        check(outs == 5'd0, "R10 reset lines", int'(outs), 0);
        check(done == 1'b0, "R10 reset done", int'(done), 0);
        run_mode = 1'b1;
        poll = 1'b1;
        repeat (50) @(negedge clk);
        check(stage == 3'd0, "R10 no start no move", int'(stage), 0);
        run_mode = 1'b0;
        poll = 1'b0;
    endtask

    task automatic test_run_full();
        do_reset();
        delay_ms = {8'd2, 8'd3, 8'd1, 8'd2};
        present = 5'h1F;
        run_mode = 1'b1;
        @(negedge clk);
        pulse_start();
        wait_done();
        check_gaps(2, 1, 3, 2, "run");
        check(outs == 5'h1F, "R2 all lines high", int'(outs), 31);
        check(stage == 3'd6, "R1 done stage", int'(stage), 6);
        for (int i = 0; i < 5; i++) begin
            check(t_out[i] == t_stage[i + 2], "R2 line rises with stage", t_out[i], t_stage[i + 2]);
        end
    endtask

    task automatic test_absent();
        do_reset();
        delay_ms = {8'd1, 8'd1, 8'd1, 8'd1};
        present = 5'b10101;
        run_mode = 1'b1;
        @(negedge clk);
        pulse_start();
        wait_done();
        check_gaps(1, 1, 1, 1, "absent R5");
        check(outs == 5'b10101, "R5 absent lines low", int'(outs), 21);
        present = 5'h1F;
    endtask

    task automatic test_zero_waits();
        do_reset();
        delay_ms = '0;
        run_mode = 1'b1;
        @(negedge clk);
        pulse_start();
        wait_done();
        check_gaps(0, 0, 0, 0, "zero R4");
        check(t_stage[6] - ts == 6, "R4 zero waits total", t_stage[6] - ts, 6);
    endtask

    task automatic test_polled();
        do_reset();
        delay_ms = {8'd1, 8'd1, 8'd1, 8'd2};
        run_mode = 1'b0;
        @(negedge clk);
        pulse_start();
        poll_at(1);
        check(stage == 3'd1, "R7 poll leaves start", int'(stage), 1);
        poll_at(1);
        check(stage == 3'd2 && panel_vdd, "R7 poll panel stage", int'(stage), 2);
        poll_at(1);
        check(stage == 3'd2, "R7 early poll holds", int'(stage), 2);
        poll_at(1998);
        check(stage == 3'd2, "R7 poll one edge early holds", int'(stage), 2);
        poll_at(1);
        check(stage == 3'd3 && lvds_en, "R7 poll at deadline advances", int'(stage), 3);
        repeat (3000) @(negedge clk);
        check(stage == 3'd3, "R7 due without poll holds", int'(stage), 3);
        run_mode = 1'b1;
        wait_done();
        check(outs == 5'h1F, "R6 finish after mode change", int'(outs), 31);
    endtask

    task automatic test_done_sticky();
        pulse_start();
        poll_at(1);
        poll_at(2);
        run_mode = 1'b0;
        poll_at(1);
        repeat (5) @(negedge clk);
        check(stage == 3'd6 && done, "R9 done holds", int'(stage), 6);
        check(outs == 5'h1F, "R9 lines unchanged", int'(outs), 31);
    endtask

    task automatic test_wrap();
        do_reset();
        delay_ms = {8'd5, 8'd3, 8'd4, 8'd5};
        run_mode = 1'b1;
        @(negedge clk);
        pulse_start();
        wait_done();
        check_gaps(5, 4, 3, 5, "wrap R8");
        check(cyc > 16384, "R8 counter wrapped during run", cyc, 16385);
    endtask

    initial begin
        test_reset();
        test_run_full();
        test_absent();
        test_zero_waits();
        test_polled();
        test_done_sticky();
        test_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule